// File: doc/BRIEF.md
# SSI Absolute Encoder Reader

This block is the master end of a synchronous serial link to an absolute position encoder. When a read is requested, or continuously when free-running, it drives one burst of clock pulses to the encoder. The line rests high between bursts. Each burst starts with a falling edge. The encoder data line is sampled on every rising edge the block produces. A burst carries one more pulse than the position has bits, and the first sampled bit is dropped. After the last rising edge the clock is held high for a programmed pause, which the encoder needs to release its latched value. The next burst cannot begin until that pause has elapsed.

Both the encoder clock and the pause are counted in system clock cycles. A 13-bit position at 1 MHz with a 12 µs gap, from a 100 MHz system clock, needs a half period of 50 cycles and a pause of 1200 cycles. A read request that arrives while a burst or a pause is under way is remembered. It is served right after the pause ends, so the gap stays the same whether the requests come early or late. Each captured word appears on the position output together with a single-cycle valid strobe.

Top module: `ssi_enc_reader`

## Requirements
- R1: While reset is asserted and after it is released, the encoder clock is high, the valid strobe is low and the position output is zero, until a read is requested.
- R2: Every frame contains exactly DATA_BITS+1 falling and DATA_BITS+1 rising edges on the encoder clock, beginning with a falling edge and ending high.
- R3: Within a burst each low phase and each high phase of the encoder clock lasts exactly half_period_i system cycles (values from 1 upward).
- R4: The data line is sampled on each rising edge and shifted in most significant bit first; the position equals the last DATA_BITS of the DATA_BITS+1 samples, and the first sample is discarded.
- R5: position_valid_o is high for exactly one system cycle per frame, in the cycle the final rising edge appears, and position_o changes only in that cycle.
- R6: When another frame is due, the encoder clock stays high for exactly pause_len_i system cycles (values from 1 upward) between the final rising edge of one frame and the first falling edge of the next.
- R7: Any number of start pulses received during a burst or its pause produce exactly one further frame, and that frame begins as soon as the pause ends.
- R8: With free_run_i held high, frames repeat back to back, separated by the pause; when it is lowered, the frame under way completes and no further frame starts.
- R9: With no start and free-running off, the encoder clock stays high and the data line is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| half_period_i | input | DIV_W | System cycles per encoder clock half period |
| pause_len_i | input | PAUSE_W | System cycles of idle-high gap after each frame |
| start_i | input | 1 | Request one frame |
| free_run_i | input | 1 | Read frames continuously |
| enc_clk_o | output | 1 | Clock to the encoder, idles high |
| enc_data_i | input | 1 | Serial data from the encoder |
| position_o | output | DATA_BITS | Last captured position |
| position_valid_o | output | 1 | One-cycle strobe when a new position is available |

## Verification
The bench targets the edges of the frame. An off-by-one pulse count would show up as a wrong number of falls or a shifted position word. If the leading sample were kept instead of dropped, random leading bits would leak into the position. Start pulses placed inside a burst test request handling: a design that drops them never issues the second frame, and one that counts them issues extra frames. The gap after a held request and the gap in free-running mode are both measured. A pause that is one cycle short, or one where the burst's opening half period is added on top, fails that measurement. Random half periods from 1 to 4 and pauses from 1 to 16 catch counters that assume a period longer than one cycle.

// File: rtl/ssi_pkg.sv
package ssi_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BURST = 2'd1,
    ST_PAUSE = 2'd2
  } ssi_state_e;
endpackage

// File: rtl/ssi_cycle_timer.sv
// Counts system cycles while run_i is high and flags the last cycle of each
// period. A period of zero is treated as one.
module ssi_cycle_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] period_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] term_m1;

  always_comb begin
    term_m1 = (period_i == '0) ? '0 : period_i - 1'b1;
    tick_o  = run_i && (cnt_q >= term_m1);
    if (!run_i || tick_o) cnt_d = '0;
    else                  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R3 / R6: an idle timer starts every period from zero
  a_r3_timer_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/ssi_frame_ctrl.sv
// Sequencer: idle, clock burst, pause. Owns the encoder clock line and the
// held start request.
module ssi_frame_ctrl
  import ssi_pkg::*;
#(
  parameter int unsigned DATA_BITS = 13
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic free_run_i,
  input  logic half_tick_i,
  input  logic gap_done_i,
  output logic enc_clk_o,
  output logic burst_o,
  output logic pause_o,
  output logic sample_o,
  output logic last_o
);
  localparam int unsigned PULSES   = DATA_BITS + 1;
  localparam int unsigned LAST_EDG = 2 * PULSES - 1;
  localparam int unsigned EW       = $clog2(2 * PULSES + 1);
  localparam logic [EW-1:0] LAST_E = EW'(LAST_EDG);

  ssi_state_e    state_q, state_d;
  logic          clk_q, clk_d;
  logic [EW-1:0] edge_q, edge_d;
  logic          pend_q, pend_d;
  logic          go;

  always_comb begin
    go      = start_i | pend_q | free_run_i;
    state_d = state_q;
    clk_d   = clk_q;
    edge_d  = edge_q;
    pend_d  = pend_q;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          state_d = ST_BURST;
          clk_d   = 1'b0;
          edge_d  = EW'(1);
          pend_d  = 1'b0;
        end
      end
      ST_BURST: begin
        if (start_i) pend_d = 1'b1;
        if (half_tick_i) begin
          clk_d  = ~clk_q;
          edge_d = edge_q + 1'b1;
          if (edge_q == LAST_E) state_d = ST_PAUSE;
        end
      end
      ST_PAUSE: begin
        if (start_i) pend_d = 1'b1;
        if (gap_done_i) begin
          if (go) begin
            state_d = ST_BURST;
            clk_d   = 1'b0;
            edge_d  = EW'(1);
            pend_d  = 1'b0;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        state_d = ST_IDLE;
        clk_d   = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      clk_q   <= 1'b1;
      edge_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      clk_q   <= clk_d;
      edge_q  <= edge_d;
      pend_q  <= pend_d;
    end
  end

  assign enc_clk_o = clk_q;
  assign burst_o   = (state_q == ST_BURST);
  assign pause_o   = (state_q == ST_PAUSE);
  assign sample_o  = burst_o && half_tick_i && !clk_q;
  assign last_o    = sample_o && (edge_q == LAST_E);

  // R1 / R9: the line is high whenever no burst runs
  a_r1_idle_clk_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_BURST) |-> clk_q);
  // R7: a held request never survives into idle
  a_r7_idle_no_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !pend_q);
  // R2: edge count stays inside one frame
  a_r2_edge_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST) |-> (edge_q >= EW'(1) && edge_q <= LAST_E));
  // R6: the pause is entered only on a rising edge of the line
  a_r6_pause_on_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_BURST && half_tick_i && edge_q == LAST_E) |=> (clk_q && state_q == ST_PAUSE));
endmodule

// File: rtl/ssi_shift_capture.sv
// Shifts the data line in on each rising edge and publishes the low
// DATA_BITS of the frame with a one-cycle strobe.
module ssi_shift_capture #(
  parameter int unsigned DATA_BITS = 13
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic                 last_i,
  input  logic                 data_i,
  output logic [DATA_BITS-1:0] position_o,
  output logic                 valid_o
);
  localparam int unsigned SW = DATA_BITS + 1;

  logic [SW-1:0]        sh_q, sh_d;
  logic [DATA_BITS-1:0] pos_q, pos_d;
  logic                 val_q, val_d;

  always_comb begin
    sh_d  = sh_q;
    pos_d = pos_q;
    val_d = 1'b0;
    if (sample_i) sh_d = {sh_q[SW-2:0], data_i};
    if (last_i) begin
      pos_d = sh_d[DATA_BITS-1:0];
      val_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      pos_q <= '0;
      val_q <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      pos_q <= pos_d;
      val_q <= val_d;
    end
  end

  assign position_o = pos_q;
  assign valid_o    = val_q;

  // R5: strobe lasts a single cycle
  a_r5_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5: position changes only together with the strobe
  a_r5_hold_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(position_o));
  // R4: frame completion always coincides with a sample
  a_r4_last_is_sample: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |-> sample_i);
endmodule

// File: rtl/ssi_enc_reader.sv
module ssi_enc_reader #(
  parameter int unsigned DATA_BITS = 13,
  parameter int unsigned DIV_W     = 8,
  parameter int unsigned PAUSE_W   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DIV_W-1:0]     half_period_i,
  input  logic [PAUSE_W-1:0]   pause_len_i,
  input  logic                 start_i,
  input  logic                 free_run_i,
  output logic                 enc_clk_o,
  input  logic                 enc_data_i,
  output logic [DATA_BITS-1:0] position_o,
  output logic                 position_valid_o
);
  logic burst, pause, half_tick, gap_done, sample, last;

  ssi_cycle_timer #(.W(DIV_W)) u_half (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (burst),
    .period_i (half_period_i),
    .tick_o   (half_tick)
  );

  ssi_cycle_timer #(.W(PAUSE_W)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (pause),
    .period_i (pause_len_i),
    .tick_o   (gap_done)
  );

  ssi_frame_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .free_run_i  (free_run_i),
    .half_tick_i (half_tick),
    .gap_done_i  (gap_done),
    .enc_clk_o   (enc_clk_o),
    .burst_o     (burst),
    .pause_o     (pause),
    .sample_o    (sample),
    .last_o      (last)
  );

  ssi_shift_capture #(.DATA_BITS(DATA_BITS)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_i   (sample),
    .last_i     (last),
    .data_i     (enc_data_i),
    .position_o (position_o),
    .valid_o    (position_valid_o)
  );

  // R8 / R9: a frame strobe can only follow burst activity
  a_r9_strobe_after_burst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    position_valid_o |-> (pause && enc_clk_o));
endmodule

// File: tb/tb_ssi_enc_reader.sv
module tb_ssi_enc_reader;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 13;
  localparam int LIMIT      = 150000;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [7:0]     half_period;
  logic [15:0]    pause_len;
  logic           start, free_run, enc_data;
  logic           enc_clk, position_valid;
  logic [N-1:0]   position;

  int checks = 0, fails = 0;
  int cur_div = 1, cur_pause = 1;
  int fall_idx = 0, rise_idx = 0, fall_total = 0, valid_cnt = 0;
  int high_len = 0, low_len = 0;
  bit have_prev = 0, expect_b2b = 0, prev_eclk = 1, prev_valid = 0;
  logic [N-1:0] prev_pos = '0;
  logic [N:0]   word;

  always #(CLK_PERIOD/2) clk = ~clk;

  ssi_enc_reader dut (
    .clk_i(clk), .rst_ni(rst_n), .half_period_i(half_period),
    .pause_len_i(pause_len), .start_i(start), .free_run_i(free_run),
    .enc_clk_o(enc_clk), .enc_data_i(enc_data), .position_o(position),
    .position_valid_o(position_valid));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // encoder model and monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_eclk && !enc_clk) begin
        if (fall_idx == 0 && have_prev && expect_b2b)
          check(high_len == cur_pause, "R6 gap", high_len, cur_pause);
        else if (fall_idx > 0)
          check(high_len == cur_div, "R3 high phase", high_len, cur_div);
        if (fall_idx <= N) enc_data = word[N - fall_idx];
        fall_idx++; fall_total++; low_len = 0;
      end
      if (!prev_eclk && enc_clk) begin
        check(low_len == cur_div, "R3 low phase", low_len, cur_div);
        rise_idx++; high_len = 0;
      end
      if (enc_clk) high_len++; else low_len++;
      if (position_valid) begin
        check(fall_idx == N+1 && rise_idx == N+1, "R2 edge count", fall_idx*100+rise_idx, (N+1)*101);
        check(position == word[N-1:0], "R4 position", int'(position), int'(word[N-1:0]));
        check(!prev_valid, "R5 strobe width", 2, 1);
        valid_cnt++; have_prev = 1;
        fall_idx = 0; rise_idx = 0;
        word = (N+1)'($urandom);
        enc_data = 1'($urandom);
      end else if (position != prev_pos) begin
        check(0, "R5 position hold", int'(position), int'(prev_pos));
      end
      prev_eclk  = enc_clk;
      prev_valid = position_valid;
      prev_pos   = position;
    end
  end

  task automatic wait_valids(input int n);
    int target = valid_cnt + n;
    while (valid_cnt < target) @(negedge clk);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic set_timing(input int d, input int p);
    cur_div = d; cur_pause = p;
    half_period = 8'(d); pause_len = 16'(p);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual %0d expected %0d", LIMIT, 0);
    finish_run();
  end

  initial begin
    int base_v, base_f;
    void'($urandom(32'h5EED));
    rst_n = 1'b0; start = 1'b0; free_run = 1'b0; enc_data = 1'b0;
    word = (N+1)'($urandom);
    set_timing(1, 1);
    repeat (3) @(negedge clk);
    check(enc_clk === 1'b1 && position_valid === 1'b0 && position === '0, "R1 in reset", int'(enc_clk), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(enc_clk === 1'b1 && position_valid === 1'b0 && position === '0, "R1 after reset", int'(position), 0);

    // R9: idle with toggling data line
    for (int i = 0; i < 60; i++) begin @(negedge clk); enc_data = 1'($urandom); end
    check(fall_total == 0 && valid_cnt == 0 && enc_clk, "R9 idle quiet", fall_total, 0);

    // R2 R3 R4: single frame at fastest clock
    pulse_start();
    wait_valids(1);

    // R4: leading sample set, position all zero; then the reverse
    word = {1'b1, {N{1'b0}}}; set_timing(2, 3);
    pulse_start(); wait_valids(1);
    word = {1'b0, {N{1'b1}}};
    pulse_start(); wait_valids(1);

    // R7: several starts inside a burst give exactly one further frame
    set_timing(3, 7);
    base_v = valid_cnt;
    pulse_start();
    while (fall_idx < 3) @(negedge clk);
    expect_b2b = 1;
    pulse_start(); pulse_start();
    wait_valids(1);
    pulse_start();               // during the pause
    wait_valids(1);
    expect_b2b = 0;
    base_f = fall_total;
    repeat (200) @(negedge clk);
    check(valid_cnt - base_v == 2 && fall_total == base_f, "R7 one held frame", valid_cnt - base_v, 2);

    // R8: free-running frames, then stop
    set_timing(2, 5);
    base_v = valid_cnt;
    @(negedge clk); free_run = 1'b1;
    while (fall_idx < 1) @(negedge clk);
    expect_b2b = 1;
    wait_valids(4);
    free_run = 1'b0;
    expect_b2b = 0;
    base_f = fall_total;
    repeat (150) @(negedge clk);
    check(valid_cnt - base_v == 4 && fall_total == base_f && enc_clk, "R8 free run stop", valid_cnt - base_v, 4);

    // random timings
    for (int i = 0; i < 20; i++) begin
      set_timing(1 + int'($urandom_range(3)), 1 + int'($urandom_range(15)));
      repeat (int'($urandom_range(5))) @(negedge clk);
      pulse_start();
      wait_valids(1);
      repeat (cur_pause + 2) @(negedge clk);
    end

    // R9: after activity, still quiet with no request
    base_f = fall_total;
    for (int i = 0; i < 80; i++) begin @(negedge clk); enc_data = 1'($urandom); end
    check(fall_total == base_f && enc_clk, "R9 quiet after frames", fall_total - base_f, 0);

    finish_run();
  end
endmodule